// File: doc/BRIEF.md
# Banked Identification Register Read Gate

This block settles what happens when software reads one identification word out of a bank of per-monitor identification registers. A select index picks the monitor. The gate looks at the privilege level of the requester (0 to 3) and at the configuration of the higher levels. It then returns one of four verdicts: the data itself, an undefined-instruction result, a trap to level 2, or a trap to level 3. Alongside the verdict it returns the exception class and the 64-bit word. The block does not enter the exception and does not write the bank.

Each monitor has a 2-bit permission field in each of two permission vectors, one owned by level 2 and one by level 3. The field for monitor `s` sits at bits `[2s+1:2s]`, and the value 00 denies access. The checks run in a strict priority order, and that order depends on the requester level. A priority-mode flag moves the level-3 denials to the front of the chain as undefined results. A second mode flag decides whether an ordinary level-3 denial gives an undefined result or a trap to level 3.

Requests use a valid/ready handshake. A small state machine has two states. In `ST_IDLE` it accepts a request. The transition `T_ACCEPT` (request valid while idle) registers the verdict and enters `ST_HOLD`. In `ST_HOLD` the response is presented and held. The transition `T_RELEASE` (response ready while holding) returns to `ST_IDLE`. Otherwise the machine stays in `ST_HOLD` (`T_STALL`).

Top module: `idgate_top`

## Requirements
- R1: A request from level 0 gives the undefined verdict (code 01), whatever the configuration.
- R2: A request from level 3 always gives the data verdict (code 00) and returns the bank word chosen by the select index.
- R3: The permission of monitor `s` is bits `[2s+1:2s]` of each permission vector, and 00 denies. A select index at or above `N_MON` counts as denied in both vectors and returns an all-zero word.
- R4: At level 1 the priority is fixed as follows. First, the level-3 priority checks (priority mode set with the level-3 enable low, then priority mode set with the level-3 field at 00) give undefined. Next, the three level-2 checks give a trap to level 2. Last come the ordinary level-3 checks.
- R5: At level 1, with level 2 enabled and the fine-grained feature present, the verdict is a trap to level 2 (code 10) when the level-2 fine-grained read bit is 0. It is also a trap to level 2 when level 3 exists and its fine-grained enable is 0. The level-2 checks also trap when the level-2 enable is 0 or the level-2 field is 00.
- R6: At level 2 none of the level-2 checks apply. Only the level-3 priority checks and the ordinary level-3 checks apply.
- R7: A failed ordinary level-3 check (enable low or field 00) gives undefined when the debug-undefined flag is high. Otherwise it gives a trap to level 3 (code 11).
- R8: Both trap verdicts report exception class 0x18. The data and undefined verdicts report 0.
- R9: The bank word has bits [63:32] at zero. The other fields are: designer code [31:21] = `DESIGNER` (default 11'h23B), present [20] = 1, revision [19:16] = `REVISION` (default 1), version [15:12] = `VERSION` (default 2), and part [11:0] = `PART_BASE` + index (default base 12'hA50).
- R10: The response word is zero for every verdict other than data.
- R11: The response is valid in the cycle after acceptance. While it waits for `rsp_ready`, it holds steady and `req_ready` stays low. After reset, `req_ready` is high and `rsp_valid` is low.
- R12: With the level-3-implemented input low, no level-3 check applies. With the level-2-enabled input low, no level-2 check applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Gate can accept a request |
| req_el | input | 2 | Requester privilege level |
| req_sel | input | SEL_W | Monitor select index |
| have_el3 | input | 1 | Level 3 implemented |
| el2_enabled | input | 1 | Level 2 enabled |
| has_fgt | input | 1 | Fine-grained trap feature present |
| el3_fgt_en | input | 1 | Level-3 fine-grained enable |
| el2_fgt_rd | input | 1 | Level-2 fine-grained read permit |
| el3_pm_en | input | 1 | Level-3 monitor access enable |
| el2_pm_en | input | 1 | Level-2 monitor access enable |
| perm_el3 | input | 2*N_MON | Level-3 per-monitor permission fields |
| perm_el2 | input | 2*N_MON | Level-2 per-monitor permission fields |
| undef_prio | input | 1 | Level-3 denials take priority as undefined |
| undef_mode | input | 1 | Ordinary level-3 denial gives undefined |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_kind | output | 2 | Verdict: 00 data, 01 undefined, 10 trap L2, 11 trap L3 |
| rsp_ec | output | 6 | Exception class |
| rsp_data | output | 64 | Read word |

## Verification
The bench builds the block with `N_MON` = 4, so `req_sel` is 3 bits wide. Indices 4 to 7 then reach the out-of-range path for both the permission lookup and the bank word. Four monitors are enough to place distinct permission codes in every field of a vector at once. This shows that each index reads its own bit pair and not a neighbour's.

// File: rtl/idgate_pkg.sv
package idgate_pkg;
    typedef enum logic [1:0] {
        K_DATA  = 2'b00,
        K_UNDEF = 2'b01,
        K_TRAP2 = 2'b10,
        K_TRAP3 = 2'b11
    } kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } gate_state_t;

    localparam logic [5:0] EC_SYSREG = 6'h18;
    localparam logic [5:0] EC_NONE   = 6'h00;
endpackage

// File: rtl/idgate_field.sv
module idgate_field #(
    parameter int N_MON = 4,
    parameter int SEL_W = 3
) (
    input  logic [2*N_MON-1:0] perm,
    input  logic [SEL_W-1:0]   sel,
    output logic               denied
);
    logic [1:0] fld [N_MON];

    for (genvar g = 0; g < N_MON; g++) begin : g_fld
        assign fld[g] = perm[2*g+1:2*g];
    end

    logic [1:0] picked;
    always_comb begin
        picked = 2'b00;
        for (int i = 0; i < N_MON; i++) begin
            if (sel == SEL_W'(i)) picked = fld[i];
        end
    end

    assign denied = (picked == 2'b00);
endmodule

// File: rtl/idgate_bank.sv
module idgate_bank #(
    parameter int          N_MON     = 4,
    parameter int          SEL_W     = 3,
    parameter logic [10:0] DESIGNER  = 11'h23B,
    parameter logic [3:0]  REVISION  = 4'h1,
    parameter logic [3:0]  VERSION   = 4'h2,
    parameter logic [11:0] PART_BASE = 12'hA50
) (
    input  logic [SEL_W-1:0] sel,
    output logic [63:0]      word
);
    logic [63:0] entry [N_MON];

    for (genvar g = 0; g < N_MON; g++) begin : g_ent
        localparam logic [11:0] PART = PART_BASE + 12'(g);
        assign entry[g] = {32'h0, DESIGNER, 1'b1, REVISION, VERSION, PART};
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < N_MON; i++) begin
            if (sel == SEL_W'(i)) word = entry[i];
        end
    end
endmodule

// File: rtl/idgate_decide.sv
module idgate_decide
    import idgate_pkg::*;
(
    input  logic [1:0] el,
    input  logic       have_el3,
    input  logic       el2_enabled,
    input  logic       has_fgt,
    input  logic       el3_fgt_en,
    input  logic       el2_fgt_rd,
    input  logic       el3_pm_en,
    input  logic       el2_pm_en,
    input  logic       deny3,
    input  logic       deny2,
    input  logic       undef_prio,
    input  logic       undef_mode,
    output kind_t      kind
);
    logic prio_fail, l2_fail, l3_fail;
    kind_t l3_kind;

    always_comb begin
        prio_fail = have_el3 && undef_prio && (!el3_pm_en || deny3);
        l2_fail   = el2_enabled && (
                        (has_fgt && ((have_el3 && !el3_fgt_en) || !el2_fgt_rd))
                        || !el2_pm_en
                        || deny2);
        l3_fail   = have_el3 && (!el3_pm_en || deny3);
        l3_kind   = undef_mode ? K_UNDEF : K_TRAP3;
    end

    always_comb begin
        unique case (el)
            2'd0: kind = K_UNDEF;
            2'd1: begin
                if (prio_fail)    kind = K_UNDEF;
                else if (l2_fail) kind = K_TRAP2;
                else if (l3_fail) kind = l3_kind;
                else              kind = K_DATA;
            end
            2'd2: begin
                if (prio_fail)    kind = K_UNDEF;
                else if (l3_fail) kind = l3_kind;
                else              kind = K_DATA;
            end
            default: kind = K_DATA;
        endcase
    end
endmodule

// File: rtl/idgate_top.sv
module idgate_top
    import idgate_pkg::*;
#(
    parameter int          N_MON     = 4,
    parameter logic [10:0] DESIGNER  = 11'h23B,
    parameter logic [3:0]  REVISION  = 4'h1,
    parameter logic [3:0]  VERSION   = 4'h2,
    parameter logic [11:0] PART_BASE = 12'hA50,
    localparam int         SEL_W     = $clog2(N_MON) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_el,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic               have_el3,
    input  logic               el2_enabled,
    input  logic               has_fgt,
    input  logic               el3_fgt_en,
    input  logic               el2_fgt_rd,
    input  logic               el3_pm_en,
    input  logic               el2_pm_en,
    input  logic [2*N_MON-1:0] perm_el3,
    input  logic [2*N_MON-1:0] perm_el2,
    input  logic               undef_prio,
    input  logic               undef_mode,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [1:0]         rsp_kind,
    output logic [5:0]         rsp_ec,
    output logic [63:0]        rsp_data
);
    logic        deny3, deny2;
    logic [63:0] bank_word;
    kind_t       verdict;

    idgate_field #(.N_MON(N_MON), .SEL_W(SEL_W)) u_f3 (
        .perm(perm_el3), .sel(req_sel), .denied(deny3));
    idgate_field #(.N_MON(N_MON), .SEL_W(SEL_W)) u_f2 (
        .perm(perm_el2), .sel(req_sel), .denied(deny2));

    idgate_bank #(
        .N_MON(N_MON), .SEL_W(SEL_W), .DESIGNER(DESIGNER),
        .REVISION(REVISION), .VERSION(VERSION), .PART_BASE(PART_BASE)
    ) u_bank (.sel(req_sel), .word(bank_word));

    idgate_decide u_dec (
        .el(req_el), .have_el3(have_el3), .el2_enabled(el2_enabled),
        .has_fgt(has_fgt), .el3_fgt_en(el3_fgt_en), .el2_fgt_rd(el2_fgt_rd),
        .el3_pm_en(el3_pm_en), .el2_pm_en(el2_pm_en),
        .deny3(deny3), .deny2(deny2),
        .undef_prio(undef_prio), .undef_mode(undef_mode),
        .kind(verdict));

    gate_state_t state, state_nx;
    kind_t       kind_q;
    logic [63:0] data_q;
    logic        accept;

    assign accept = req_valid && (state == ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_HOLD;  // T_ACCEPT
            ST_HOLD: if (rsp_ready) state_nx = ST_IDLE;  // T_RELEASE, else T_STALL
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_DATA;
            data_q <= '0;
        end else if (accept) begin
            kind_q <= verdict;
            data_q <= (verdict == K_DATA) ? bank_word : '0;
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_HOLD);
        rsp_kind  = kind_q;
        rsp_data  = data_q;
        rsp_ec    = (kind_q == K_TRAP2 || kind_q == K_TRAP3) ? EC_SYSREG : EC_NONE;
    end

    a_r1_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_el == 2'd0) |=> (rsp_valid && rsp_kind == K_UNDEF));
    a_r2_el3_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_el == 2'd3) |=> (rsp_valid && rsp_kind == K_DATA));
    a_r8_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind[1]) |-> (rsp_ec == 6'h18));
    a_r10_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != K_DATA) |-> (rsp_data == 64'h0));
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_data[63:32] == 32'h0));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && !req_ready
                                       && $stable(rsp_kind) && $stable(rsp_data)));
endmodule

// File: tb/idgate_top_test.sv
module idgate_top_test;
    localparam int N = 4;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, rsp_ready = 1'b1;
    logic [1:0] req_el = 2'd0;
    logic [SW-1:0] req_sel = '0;
    logic have_el3, el2_enabled, has_fgt, el3_fgt_en, el2_fgt_rd;
    logic el3_pm_en, el2_pm_en, undef_prio, undef_mode;
    logic [2*N-1:0] perm_el3, perm_el2;
    logic req_ready, rsp_valid;
    logic [1:0] rsp_kind;
    logic [5:0] rsp_ec;
    logic [63:0] rsp_data;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    idgate_top #(.N_MON(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_el(req_el), .req_sel(req_sel), .have_el3(have_el3),
        .el2_enabled(el2_enabled), .has_fgt(has_fgt), .el3_fgt_en(el3_fgt_en),
        .el2_fgt_rd(el2_fgt_rd), .el3_pm_en(el3_pm_en), .el2_pm_en(el2_pm_en),
        .perm_el3(perm_el3), .perm_el2(perm_el2), .undef_prio(undef_prio),
        .undef_mode(undef_mode), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_kind(rsp_kind), .rsp_ec(rsp_ec), .rsp_data(rsp_data));

    function automatic logic [63:0] word_of(int idx);
        logic [11:0] part;
        part = 12'hA50 + 12'(idx);
        return {32'h0, 11'h23B, 1'b1, 4'h1, 4'h2, part};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic open_cfg();
        have_el3 = 1; el2_enabled = 1; has_fgt = 1; el3_fgt_en = 1; el2_fgt_rd = 1;
        el3_pm_en = 1; el2_pm_en = 1; undef_prio = 0; undef_mode = 0;
        perm_el3 = '1; perm_el2 = '1;
    endtask

    // one request; checks verdict, class (R8) and word (R10)
    task automatic issue(string req, logic [1:0] el, int sel, logic [1:0] ek, logic [63:0] ew);
        @(negedge clk);
        req_el = el; req_sel = SW'(sel); req_valid = 1; rsp_ready = 1;
        @(negedge clk);
        req_valid = 0;
        check({req, " R11 valid"}, 64'(rsp_valid), 64'd1);
        check({req, " kind"}, 64'(rsp_kind), 64'(ek));
        check({req, " R8 class"}, 64'(rsp_ec), (ek[1] ? 64'h18 : 64'h0));
        check({req, " R10 word"}, rsp_data, (ek == 2'b00) ? ew : 64'h0);
    endtask

    task automatic t_reset();
        check("R11 reset ready", 64'(req_ready), 64'd1);
        check("R11 reset valid", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_level0();
        open_cfg();
        issue("R1 el0", 2'd0, 1, 2'b01, 0);
    endtask

    task automatic t_level3();
        open_cfg();
        perm_el3 = '0; perm_el2 = '0; el3_pm_en = 0; el2_pm_en = 0; undef_prio = 1;
        issue("R2 R9 el3 sel2", 2'd3, 2, 2'b00, word_of(2));
        issue("R3 el3 sel5 out of range", 2'd3, 5, 2'b00, 64'h0);
        open_cfg();
        issue("R9 el1 sel3", 2'd1, 3, 2'b00, word_of(3));
    endtask

    task automatic t_fields();
        open_cfg();
        perm_el2 = 8'b11_01_00_10;
        issue("R3 L2 field sel1=00", 2'd1, 1, 2'b10, 0);
        issue("R3 L2 field sel0=10", 2'd1, 0, 2'b00, word_of(0));
        issue("R3 L2 field sel2=01", 2'd1, 2, 2'b00, word_of(2));
        open_cfg();
        perm_el3 = 8'b11_00_11_11;
        issue("R3 L3 field sel2=00", 2'd1, 2, 2'b11, 0);
        issue("R3 L3 field sel3=11", 2'd1, 3, 2'b00, word_of(3));
        open_cfg();
        issue("R3 sel6 denied", 2'd1, 6, 2'b10, 0);
    endtask

    task automatic t_priority();
        open_cfg();
        undef_prio = 1; el3_pm_en = 0; el2_pm_en = 0;
        issue("R4 prio enable beats L2", 2'd1, 0, 2'b01, 0);
        open_cfg();
        undef_prio = 1; perm_el3 = 8'b11_11_00_11; el2_fgt_rd = 0;
        issue("R4 prio field beats L2", 2'd1, 1, 2'b01, 0);
        open_cfg();
        el2_pm_en = 0; el3_pm_en = 0;
        issue("R4 L2 before L3", 2'd1, 0, 2'b10, 0);
    endtask

    task automatic t_finegrain();
        open_cfg(); el2_fgt_rd = 0;
        issue("R5 read bit", 2'd1, 0, 2'b10, 0);
        open_cfg(); el3_fgt_en = 0;
        issue("R5 L3 fg enable", 2'd1, 0, 2'b10, 0);
        open_cfg(); el3_fgt_en = 0; have_el3 = 0;
        issue("R12 no L3 fg ignored", 2'd1, 1, 2'b00, word_of(1));
        open_cfg(); has_fgt = 0; el2_fgt_rd = 0;
        issue("R5 feature absent", 2'd1, 1, 2'b00, word_of(1));
        open_cfg(); el2_pm_en = 0;
        issue("R5 L2 enable", 2'd1, 2, 2'b10, 0);
    endtask

    task automatic t_level2();
        open_cfg(); el2_pm_en = 0; perm_el2 = '0; el2_fgt_rd = 0;
        issue("R6 el2 skips L2", 2'd2, 3, 2'b00, word_of(3));
        open_cfg(); el3_pm_en = 0;
        issue("R7 el2 trap3", 2'd2, 0, 2'b11, 0);
        undef_mode = 1;
        issue("R7 el2 undef mode", 2'd2, 0, 2'b01, 0);
        open_cfg(); undef_prio = 1; el3_pm_en = 0;
        issue("R6 el2 prio undef", 2'd2, 0, 2'b01, 0);
        open_cfg(); perm_el3 = 8'b00_11_11_11; undef_mode = 1;
        issue("R7 el1 field undef", 2'd1, 3, 2'b01, 0);
    endtask

    task automatic t_disabled();
        open_cfg(); el2_enabled = 0; el2_pm_en = 0; perm_el2 = '0;
        issue("R12 L2 off", 2'd1, 0, 2'b00, word_of(0));
        open_cfg(); have_el3 = 0; el3_pm_en = 0; perm_el3 = '0; undef_prio = 1;
        issue("R12 L3 off", 2'd1, 2, 2'b00, word_of(2));
    endtask

    task automatic t_stall();
        open_cfg();
        @(negedge clk);
        req_el = 2'd3; req_sel = SW'(1); req_valid = 1; rsp_ready = 0;
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 3; k++) begin
            check("R11 held valid", 64'(rsp_valid), 64'd1);
            check("R11 ready low", 64'(req_ready), 64'd0);
            check("R11 held word", rsp_data, word_of(1));
            @(negedge clk);
        end
        rsp_ready = 1;
        @(negedge clk);
        check("R11 released", 64'(rsp_valid), 64'd0);
        check("R11 ready again", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R11 watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        open_cfg();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_level0();
        t_level3();
        t_fields();
        t_priority();
        t_finegrain();
        t_level2();
        t_disabled();
        t_stall();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule